// File: doc/BRIEF.md
# Priority Bus Arbiter with Burst Pre-emption Timer

This block is a central arbiter that decides which of up to sixteen bus masters owns a shared bus. Every master raises a request and drives a two-bit priority code alongside it. The arbiter samples these inputs on each rising clock edge. The grant it decides on is registered, so it shows on the outputs just after that edge as a one-hot vector plus a valid flag. When several masters share the top requested level, a mode input picks the winner in one of two ways: lowest index first, or a rotating pointer kept separately for each level.

A master that is in the middle of a burst keeps the bus, but only for a limited time. When the grant is issued, a countdown is loaded from a programmable limit. The countdown runs only while the burst is active and a master with a strictly higher level is waiting. Once it reaches zero, the waiting master takes over at the next edge. A lock input lets the owner hold the bus through an atomic sequence. Neither re-arbitration nor the countdown can take the bus away while the lock is held. When nobody requests, the grant stays parked on the last owner and the valid flag drops.

Top module: `prio_burst_arbiter`

## Requirements
- R1: After reset, grantValid is low and grantOneHot selects master 0.
- R2: The requester with the numerically largest priority code (3 highest, 0 lowest) wins. The grant appears just after the clock edge at which the requests were sampled.
- R3: With rrMode low, ties at the top level go to the lowest-indexed requester.
- R4: With rrMode high, a tie goes to the first requester at or after that level's pointer, counting upward and wrapping. Each grant moves that level's pointer to the winner's index plus one, wrapping after the last master. All pointers start at 0.
- R5: Outside a burst and without lock, arbitration is repeated on every edge. If no master requests, grantValid goes low and grantOneHot stays on the last owner.
- R6: While the owner keeps requesting and lockIn is high, the owner keeps the grant, whatever other requests, priorities, burst state or timer value are present.
- R7: While burstActive is high and the owner keeps requesting, the owner keeps the grant as long as no requester has a strictly higher level. Equal- or lower-level requests neither take the bus nor advance the countdown.
- R8: The countdown is loaded from timeoutLimit on every grant. It decrements on each edge where the burst is active, a strictly higher request waits and the lock is not held. The edge after it reaches zero under those conditions hands the bus to the higher requester. With limit L, the higher master is granted L+1 edges after it starts waiting; with L=0 this happens at the first edge.
- R9: grantOneHot always has exactly one bit set.
- R10: Whenever grantValid is high, the granted master was requesting at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqVec | input | NUM_MASTERS | Request, one bit per master |
| prioVec | input | 2*NUM_MASTERS | Priority code of master i at bits 2i+1:2i |
| rrMode | input | 1 | 1 = rotating tie-break, 0 = lowest index |
| lockIn | input | 1 | Owner asks to keep the bus |
| burstActive | input | 1 | Owner is in the middle of a burst |
| timeoutLimit | input | TIMER_W | Countdown reload value |
| grantOneHot | output | NUM_MASTERS | Current or parked owner |
| grantValid | output | 1 | Owner holds a live grant |

## Verification
The lock hold and the expiry of the countdown can fall due in the same cycle. The bench provokes this with a zero limit, an active burst and a higher-level requester, all while the owner holds the lock. The grant must stay with the owner for several edges. When the lock drops, the waiting master must win at the very next edge. In a second case, an equal-level requester waits during a burst with a zero limit, and the owner must not be pre-empted.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef logic [1:0] prio_t;

  // control to datapath
  typedef struct packed {
    logic take;   // load owner with current winner
    logic idle;   // drop the valid flag, keep owner parked
  } arbStrobe_t;

  // datapath to control
  typedef struct packed {
    logic anyReq;
    logic ownerReq;
    logic higherPend;
    logic ownerValid;
  } arbStatus_t;
endpackage

// File: rtl/prio_arb_path.sv
module prio_arb_path #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [N-1:0]          reqVec,
  input  logic [2*N-1:0]        prioVec,
  input  logic                  rrMode,
  input  arb_pkg::arbStrobe_t   strobe,
  output arb_pkg::arbStatus_t   status,
  output logic [N-1:0]          grantOneHot,
  output logic                  grantValid
);
  import arb_pkg::*;

  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

  prio_t          prioArr [N];
  logic [N-1:0]   candMask;
  prio_t          lvlMax;
  logic [IW-1:0]  winFix, winRr, winner, nextPtr;
  logic [IW-1:0]  ownerQ;
  logic           validQ;
  logic [IW-1:0]  ptrQ [4];
  logic           higher;

  for (genvar gi = 0; gi < N; gi++) begin : g_unpack
    assign prioArr[gi]     = prioVec[2*gi +: 2];
    assign candMask[gi]    = reqVec[gi] && (prioArr[gi] == lvlMax);
    assign grantOneHot[gi] = (ownerQ == IW'(gi));
  end

  always_comb begin
    lvlMax = 2'd0;
    for (int i = 0; i < N; i++)
      if (reqVec[i] && prioArr[i] > lvlMax) lvlMax = prioArr[i];
  end

  // lowest index among ties
  always_comb begin
    logic found;
    found  = 1'b0;
    winFix = '0;
    for (int i = 0; i < N; i++)
      if (!found && candMask[i]) begin
        winFix = IW'(i);
        found  = 1'b1;
      end
  end

  // first tie candidate at or after the level pointer
  always_comb begin
    logic found;
    int   idx;
    found = 1'b0;
    winRr = '0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptrQ[lvlMax]) + k;
      if (idx >= N) idx = idx - N;
      if (!found && candMask[idx]) begin
        winRr = IW'(idx);
        found = 1'b1;
      end
    end
  end

  assign winner  = rrMode ? winRr : winFix;
  assign nextPtr = (winner == LAST_IDX) ? '0 : winner + 1'b1;

  always_comb begin
    higher = 1'b0;
    for (int i = 0; i < N; i++)
      if (reqVec[i] && prioArr[i] > prioArr[ownerQ]) higher = 1'b1;
  end

  assign status.anyReq     = |reqVec;
  assign status.ownerReq   = reqVec[ownerQ];
  assign status.higherPend = higher;
  assign status.ownerValid = validQ;
  assign grantValid        = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerQ <= '0;
      validQ <= 1'b0;
      for (int l = 0; l < 4; l++) ptrQ[l] <= '0;
    end else if (strobe.take) begin
      ownerQ       <= winner;
      validQ       <= 1'b1;
      ptrQ[lvlMax] <= nextPtr;
    end else if (strobe.idle) begin
      validQ <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_arb_ctrl.sv
module prio_arb_ctrl #(
  parameter int TW = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  arb_pkg::arbStatus_t  status,
  input  logic                 lockIn,
  input  logic                 burstActive,
  input  logic [TW-1:0]        timeoutLimit,
  output arb_pkg::arbStrobe_t  strobe
);
  logic [TW-1:0] timerQ;
  logic ownerLive, lockHeld, contend, expired, preempt, keep;

  assign ownerLive = status.ownerValid && status.ownerReq;
  assign lockHeld  = ownerLive && lockIn;
  assign contend   = ownerLive && burstActive && status.higherPend && !lockHeld;
  assign expired   = (timerQ == '0);
  assign preempt   = contend && expired;
  assign keep      = lockHeld || (ownerLive && burstActive && !preempt);

  assign strobe.take = status.anyReq && !keep;
  assign strobe.idle = !status.anyReq && !keep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      timerQ <= '0;
    else if (strobe.take)           timerQ <= timeoutLimit;
    else if (contend && !expired)   timerQ <= timerQ - 1'b1;
  end
endmodule

// File: rtl/prio_burst_arbiter.sv
module prio_burst_arbiter #(
  parameter int NUM_MASTERS = 16,
  parameter int TIMER_W     = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_MASTERS-1:0]   reqVec,
  input  logic [2*NUM_MASTERS-1:0] prioVec,
  input  logic                     rrMode,
  input  logic                     lockIn,
  input  logic                     burstActive,
  input  logic [TIMER_W-1:0]       timeoutLimit,
  output logic [NUM_MASTERS-1:0]   grantOneHot,
  output logic                     grantValid
);
  arb_pkg::arbStrobe_t strobe;
  arb_pkg::arbStatus_t status;

  prio_arb_path #(.N(NUM_MASTERS)) u_path (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .prioVec(prioVec),
    .rrMode(rrMode), .strobe(strobe), .status(status),
    .grantOneHot(grantOneHot), .grantValid(grantValid)
  );

  prio_arb_ctrl #(.TW(TIMER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .status(status), .lockIn(lockIn),
    .burstActive(burstActive), .timeoutLimit(timeoutLimit), .strobe(strobe)
  );
endmodule

// File: rtl/prio_arb_chk.sv
module prio_arb_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic [N-1:0] reqVec,
  input logic         lockIn,
  input logic [N-1:0] grantOneHot,
  input logic         grantValid
);
  // R9
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grantOneHot) == 1);

  // R10
  a_r10_to_requester: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> |(grantOneHot & $past(reqVec)));

  // R6
  a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && lockIn && |(grantOneHot & reqVec))
      |=> (grantValid && $stable(grantOneHot)));

  // R5
  a_r5_park: assert property (@(posedge clk) disable iff (!rstN)
    (reqVec == '0) |=> (!grantValid && $stable(grantOneHot)));
endmodule

bind prio_burst_arbiter prio_arb_chk #(.N(NUM_MASTERS)) u_chk (
  .clk(clk), .rstN(rstN), .reqVec(reqVec), .lockIn(lockIn),
  .grantOneHot(grantOneHot), .grantValid(grantValid)
);

// File: tb/prio_burst_arbiter_tb.sv
`timescale 1ns/1ps
module prio_burst_arbiter_tb;
  localparam int N  = 16;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0]   reqVec = '0;
  logic [2*N-1:0] prioVec = '0;
  logic rrMode = 1'b0, lockIn = 1'b0, burstActive = 1'b0;
  logic [TW-1:0] timeoutLimit = '0;
  logic [N-1:0] grantOneHot;
  logic grantValid;

  int total = 0;
  int bad = 0;

  prio_burst_arbiter #(.NUM_MASTERS(N), .TIMER_W(TW)) u_dut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .prioVec(prioVec),
    .rrMode(rrMode), .lockIn(lockIn), .burstActive(burstActive),
    .timeoutLimit(timeoutLimit), .grantOneHot(grantOneHot),
    .grantValid(grantValid)
  );

  always #2 clk = ~clk;

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setReq(input int idx, input logic [1:0] p);
    reqVec[idx] = 1'b1;
    prioVec[2*idx +: 2] = p;
  endtask

  task automatic clearAll();
    reqVec = '0; prioVec = '0; lockIn = 1'b0; burstActive = 1'b0;
    tick();
  endtask

  task automatic checkGrant(input int expIdx, input logic expValid, input string tag);
    logic [N-1:0] expHot;
    expHot = N'(1) << expIdx;
    total++;
    if (grantOneHot !== expHot || grantValid !== expValid) begin
      bad++;
      $display("FAIL %s: grant=%h valid=%b expected grant=%h valid=%b",
               tag, grantOneHot, grantValid, expHot, expValid);
    end
  endtask

  task automatic testReset();
    checkGrant(0, 1'b0, "R1 reset state");
  endtask

  task automatic testPriority();
    setReq(3, 2'd1); setReq(5, 2'd3); setReq(9, 2'd2);
    tick();
    checkGrant(5, 1'b1, "R2 highest level wins");
    tick();
    checkGrant(5, 1'b1, "R10 R9 repeat arbitration");
    clearAll();
  endtask

  task automatic testFixedTie();
    rrMode = 1'b0;
    setReq(2, 2'd2); setReq(7, 2'd2); setReq(11, 2'd2); setReq(4, 2'd1);
    tick();
    checkGrant(2, 1'b1, "R3 lowest index tie");
    tick();
    checkGrant(2, 1'b1, "R3 lowest index again");
    clearAll();
  endtask

  task automatic testRoundRobin();
    rrMode = 1'b1;
    setReq(2, 2'd2); setReq(7, 2'd2); setReq(11, 2'd2);
    tick(); checkGrant(7,  1'b1, "R4 rotate first");
    tick(); checkGrant(11, 1'b1, "R4 rotate second");
    tick(); checkGrant(2,  1'b1, "R4 rotate wrap");
    tick(); checkGrant(7,  1'b1, "R4 rotate again");
    rrMode = 1'b0;
    reqVec = '0;
    tick();
    checkGrant(7, 1'b0, "R5 parked after release");
    tick();
    checkGrant(7, 1'b0, "R5 still parked");
    clearAll();
  endtask

  task automatic testLock();
    setReq(4, 2'd0);
    tick(); checkGrant(4, 1'b1, "R6 owner granted");
    lockIn = 1'b1;
    setReq(8, 2'd3);
    tick(3); checkGrant(4, 1'b1, "R6 lock holds vs higher level");
    lockIn = 1'b0;
    tick(); checkGrant(8, 1'b1, "R6 release hands over");
    clearAll();
  endtask

  task automatic testTimeout();
    timeoutLimit = 8'd3;
    setReq(1, 2'd1);
    tick(); checkGrant(1, 1'b1, "R8 owner granted");
    burstActive = 1'b1;
    setReq(6, 2'd2);
    tick(3); checkGrant(1, 1'b1, "R8 burst kept until expiry");
    tick();  checkGrant(6, 1'b1, "R8 pre-empted at limit+1");
    clearAll();
  endtask

  task automatic testEqualNoPreempt();
    timeoutLimit = 8'd0;
    setReq(1, 2'd1);
    tick(); checkGrant(1, 1'b1, "R7 owner granted");
    burstActive = 1'b1;
    setReq(3, 2'd1); setReq(0, 2'd0);
    tick(10); checkGrant(1, 1'b1, "R7 equal level no pre-empt");
    setReq(12, 2'd3);
    tick(); checkGrant(12, 1'b1, "R8 zero limit immediate");
    clearAll();
  endtask

  task automatic testLockVsTimer();
    timeoutLimit = 8'd0;
    setReq(2, 2'd0);
    tick(); checkGrant(2, 1'b1, "R6 owner granted");
    lockIn = 1'b1; burstActive = 1'b1;
    setReq(10, 2'd3);
    tick(5); checkGrant(2, 1'b1, "R6 lock beats expired timer");
    lockIn = 1'b0;
    tick(); checkGrant(10, 1'b1, "R8 expiry after lock drop");
    clearAll();
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #9;
    rstN = 1'b1;
    tick();
    testReset();
    testPriority();
    testFixedTie();
    testRoundRobin();
    testLock();
    testTimeout();
    testEqualNoPreempt();
    testLockVsTimer();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule